// File: doc/BRIEF.md
# Tiled Surface Address Generator

This unit turns a two-dimensional position inside a surface into the byte offset at which that position is stored. The horizontal coordinate counts bytes along a row and the vertical coordinate counts rows. Four storage layouts are available: plain row-by-row linear storage and three tiled layouts. In every tiled layout, tiles of 4096 bytes are laid side by side across the surface pitch and numbered row after row. The wide-row tile holds 8 rows of 512 bytes. The tall tile holds 32 rows of 128 bytes, organised as columns of 16-byte units. The square tile holds 64 by 64 bytes, built from nested quadrant blocks, and suits byte-per-pixel stencil data.

For each accepted request the generator derives the number of tiles per surface row from the pitch. It can then fold higher address bits into bit 6, using a different fold for each tiled layout. A pitch that does not fit the selected tile width is flagged as an error. The result is registered, so it appears one cycle after the request with a matching valid strobe.

Top module: `tile_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, out_valid, offset and pitch_err are all 0.
- R2: out_valid equals the in_valid of the previous cycle. A cycle without in_valid leaves offset and pitch_err unchanged.
- R3: Mode 0 (linear) gives offset = mem_y*pitch + mem_x. It never swizzles and never raises pitch_err.
- R4: Mode 1 (wide-row tile) uses tiles_per_row = pitch/512 and tile = (mem_y/8)*tiles_per_row + mem_x/512. It gives offset = tile*4096 + (mem_y%8)*512 + mem_x%512.
- R5: Mode 2 (tall tile) uses tiles_per_row = pitch/128 and tile = (mem_y/32)*tiles_per_row + mem_x/128. It computes unit = ((mem_x%128)/16)*32 + mem_y%32 and gives offset = tile*4096 + unit*16 + mem_x%16.
- R6: Mode 3 (square tile) uses tiles_per_row = pitch/64 and tile = (mem_y/64)*tiles_per_row + mem_x/64. It computes b8 = ((mem_x%64)/8)*8 + (mem_y%64)/8. For each k in 2, 1, 0 it forms a two-bit index with y bit k as the upper bit and x bit k as the lower bit, giving b4, b2 and b1. The offset is tile*4096 + b8*64 + b4*16 + b2*4 + b1.
- R7: With swz_en high in mode 1, offset bit 6 becomes the XOR of the unswizzled bits 6, 9 and 10.
- R8: With swz_en high in mode 2 or mode 3, offset bit 6 becomes the XOR of the unswizzled bits 6 and 9.
- R9: In modes 1, 2 and 3, a pitch that is not a multiple of 512, 128 or 64 respectively sets pitch_err to 1 and forces offset to 0.
- R10: The offset is the 32-bit truncation of the result; any carry above bit 31 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Layout: 0 linear, 1 wide-row, 2 tall, 3 square |
| mem_x | input | CW (16) | Byte column |
| mem_y | input | CW (16) | Row |
| pitch | input | PW (20) | Surface row pitch in bytes |
| swz_en | input | 1 | Enable bit-6 address fold |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| offset | output | 32 | Byte offset |
| pitch_err | output | 1 | Pitch not a multiple of the tile width |

## Verification
The pitch check and the bit-6 fold act on the same request. When a bad pitch arrives with swz_en high, the flag must win and the offset must be exactly zero, with no folded bit left over. The bench sends misaligned pitches in every tiled mode, with swz_en both high and low. It also includes them in a random stream that sets swz_en at random. Each case is judged against a behavioural model that applies the error rule before the fold.

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int CW = 16,
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] mem_x,
  input  logic [CW-1:0] mem_y,
  input  logic [PW-1:0] pitch,
  input  logic          swz_en,
  output logic          out_valid,
  output logic [31:0]   offset,
  output logic          pitch_err
);
  localparam int OW = 32;

  logic [OW-1:0] lin_off;
  logic [OW-1:0] xt_tile, xt_off, xt_swz;
  logic [OW-1:0] yt_tile, yt_off, yt_swz;
  logic [OW-1:0] wt_tile, wt_off, wt_swz;
  logic [8:0]    yt_unit;
  logic [5:0]    wt_b8;
  logic          bad_pitch;
  logic [OW-1:0] next_off;

  assign lin_off = OW'(mem_y) * OW'(pitch) + OW'(mem_x);

  assign xt_tile = OW'(mem_y >> 3) * OW'(pitch >> 9) + OW'(mem_x >> 9);
  assign xt_off  = {xt_tile[OW-13:0], mem_y[2:0], mem_x[8:0]};
  assign xt_swz  = {xt_off[OW-1:7], xt_off[6] ^ xt_off[9] ^ xt_off[10], xt_off[5:0]};

  assign yt_tile = OW'(mem_y >> 5) * OW'(pitch >> 7) + OW'(mem_x >> 7);
  assign yt_unit = {mem_x[6:4], mem_y[4:0], 1'b0} >> 1;
  assign yt_off  = {yt_tile[OW-13:0], yt_unit[7:0], mem_x[3:0]};
  assign yt_swz  = {yt_off[OW-1:7], yt_off[6] ^ yt_off[9], yt_off[5:0]};

  assign wt_tile = OW'(mem_y >> 6) * OW'(pitch >> 6) + OW'(mem_x >> 6);
  assign wt_b8   = {mem_x[5:3], mem_y[5:3]};
  assign wt_off  = {wt_tile[OW-13:0], wt_b8,
                    mem_y[2], mem_x[2], mem_y[1], mem_x[1], mem_y[0], mem_x[0]};
  assign wt_swz  = {wt_off[OW-1:7], wt_off[6] ^ wt_off[9], wt_off[5:0]};

  always_comb begin
    case (mode)
      2'd1:    bad_pitch = |pitch[8:0];
      2'd2:    bad_pitch = |pitch[6:0];
      2'd3:    bad_pitch = |pitch[5:0];
      default: bad_pitch = 1'b0;
    endcase
  end

  always_comb begin
    case (mode)
      2'd1:    next_off = swz_en ? xt_swz : xt_off;
      2'd2:    next_off = swz_en ? yt_swz : yt_off;
      2'd3:    next_off = swz_en ? wt_swz : wt_off;
      default: next_off = lin_off;
    endcase
    if (bad_pitch) next_off = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      offset    <= '0;
      pitch_err <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        offset    <= next_off;
        pitch_err <= bad_pitch;
      end
    end
  end
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
  parameter int CW = 16,
  parameter int PW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    mode,
  input logic [CW-1:0] mem_x,
  input logic [CW-1:0] mem_y,
  input logic [PW-1:0] pitch,
  input logic          swz_en,
  input logic          out_valid,
  input logic [31:0]   offset,
  input logic          pitch_err
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(offset) && $stable(pitch_err)));
  assert_linear_no_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0) |=> !pitch_err);
  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pitch_err |-> (offset == 32'd0));
  assert_wide_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1 && !swz_en && pitch[8:0] == 9'd0)
      |=> (offset[8:0] == $past(mem_x[8:0])));
  assert_tall_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2 && pitch[6:0] == 7'd0)
      |=> (offset[3:0] == $past(mem_x[3:0])));
  assert_square_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3 && pitch[5:0] == 6'd0)
      |=> (offset[1:0] == {$past(mem_y[0]), $past(mem_x[0])}));
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.CW(CW), .PW(PW)) u_chk (.*);

// File: tb/tile_addr_gen_test.sv
module tile_addr_gen_test;
  localparam int CW = 16;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    mode = '0;
  logic [CW-1:0] mem_x = '0;
  logic [CW-1:0] mem_y = '0;
  logic [PW-1:0] pitch = '0;
  logic          swz_en = 1'b0;
  logic          out_valid;
  logic [31:0]   offset;
  logic          pitch_err;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic        e_valid = 0;
  logic [31:0] e_off = 0;
  logic        e_err = 0;

  always #5 clk = ~clk;

  tile_addr_gen #(.CW(CW), .PW(PW)) uut (.*);

  function automatic longint unsigned fold6(longint unsigned v, bit b);
    return (v & ~64'h40) | (longint'(b) << 6);
  endfunction

  function automatic void model(input int md, input longint unsigned x, y, p,
                                input bit s, output logic [31:0] o, output logic er);
    longint unsigned t, r, u;
    bit b;
    er = 0; r = 0;
    case (md)
      0: r = y * p + x;
      1: begin
        er = (p % 512) != 0;
        t = (y / 8) * (p / 512) + x / 512;
        r = t * 4096 + (y % 8) * 512 + x % 512;
        b = r[6] ^ r[9] ^ r[10];
        if (s) r = fold6(r, b);
      end
      2: begin
        er = (p % 128) != 0;
        t = (y / 32) * (p / 128) + x / 128;
        u = ((x % 128) / 16) * 32 + y % 32;
        r = t * 4096 + u * 16 + x % 16;
        b = r[6] ^ r[9];
        if (s) r = fold6(r, b);
      end
      default: begin
        er = (p % 64) != 0;
        t = (y / 64) * (p / 64) + x / 64;
        u = ((x % 64) / 8) * 8 + (y % 64) / 8;
        r = t * 4096 + u * 64
          + (((y / 4) % 2) * 2 + (x / 4) % 2) * 16
          + (((y / 2) % 2) * 2 + (x / 2) % 2) * 4
          + (y % 2) * 2 + x % 2;
        b = r[6] ^ r[9];
        if (s) r = fold6(r, b);
      end
    endcase
    if (er) r = 0;
    o = r[31:0];
  endfunction

  task automatic check(input string tag);
    n_run++;
    if (out_valid !== e_valid || offset !== e_off || pitch_err !== e_err) begin
      n_fail++;
      $display("FAIL %s: got v=%0b off=%h err=%0b, expected v=%0b off=%h err=%0b",
               tag, out_valid, offset, pitch_err, e_valid, e_off, e_err);
    end
  endtask

  task automatic step(input bit v, input int md, input int x, y, p, input bit s,
                      input string tag);
    logic [31:0] o;
    logic er;
    in_valid = v; mode = 2'(md); mem_x = CW'(x); mem_y = CW'(y);
    pitch = PW'(p); swz_en = s;
    model(md, longint'(mem_x), longint'(mem_y), longint'(pitch), s, o, er);
    @(negedge clk);
    e_valid = v;
    if (v) begin e_off = o; e_err = er; end
    check(tag);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");
    step(1, 0, 37, 5, 1000, 1, "R3 linear");
    step(1, 0, 65535, 65535, 1048575, 0, "R10 linear wrap");
    step(0, 1, 9, 9, 4096, 0, "R2 idle hold");
    step(0, 2, 1, 1, 7, 1, "R2 idle hold");
    step(1, 1, 700, 13, 2048, 0, "R4 wide tile");
    step(1, 1, 1023, 31, 4096, 1, "R7 wide swizzle");
    step(1, 1, 600, 1543, 8192, 1, "R7 wide swizzle bit10");
    step(1, 2, 300, 77, 512, 0, "R5 tall tile");
    step(1, 2, 255, 40, 1024, 1, "R8 tall swizzle");
    step(1, 3, 77, 130, 256, 0, "R6 square tile");
    step(1, 3, 63, 63, 64, 0, "R6 square corner");
    step(1, 3, 200, 91, 512, 1, "R8 square swizzle");
    step(1, 1, 20, 20, 2560 + 64, 1, "R9 bad pitch wide with swizzle");
    step(1, 2, 20, 20, 200, 0, "R9 bad pitch tall");
    step(1, 3, 20, 20, 100, 1, "R9 bad pitch square with swizzle");
    step(0, 3, 5, 5, 64, 0, "R2 hold after error");
    step(1, 3, 5, 5, 64, 0, "R9 recovery R6");
    step(1, 1, 65535, 65535, 1048064, 0, "R10 wide wrap");
    for (int i = 0; i < 600; i++) begin
      int md, p;
      md = int'($urandom_range(0, 3));
      p = int'($urandom_range(1, 2047)) * 64;
      if ($urandom_range(0, 7) == 0) p = p + int'($urandom_range(1, 63));
      step(($urandom_range(0, 4) != 0), md, int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 65535)), p, $urandom_range(0, 1) == 1,
           md == 0 ? "R3 random" : md == 1 ? "R4 R7 R9 random" :
           md == 2 ? "R5 R8 R9 random" : "R6 R8 R9 random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule